// File: doc/BRIEF.md
# Critical-Word-First Line Fill Cache

A direct-mapped cache that sits between a processor and a word-wide memory port. Every line stores several words under one shared tag, with a valid flag and a modified flag kept for each word. When an access misses, the block first writes back the modified words of the victim line, and only those. It then fetches the new line starting at the requested word. That word goes to the processor in the same cycle it arrives from memory. The remaining words follow in wrap-around order while the processor carries on.

Addresses are word addresses laid out as `{tag, index, offset}`. The offset is the low `log2(WORDS)` bits and the index is the next `log2(LINES)` bits. The processor holds `cpu_req` and its operands steady while `cpu_stall` is high. An access completes on any rising edge where `cpu_req` is high and `cpu_stall` is low. Read data is valid in that same cycle.

Top module: `cwf_cache`

## Requirements
- R1: After reset no word is valid: with no request, `cpu_stall` and `mem_req` are low, and the first access stalls and starts a memory read.
- R2: The words of a line share one tag. After a fill has completed, reads of any word of that line finish without stalling and start no memory transfer.
- R3: A line fill reads the missed word first. The remaining words follow at offsets +1, +2, +3, wrapping modulo the line length, with the same tag and index.
- R4: The stall of a missing read drops in the cycle the memory acknowledges the missed word, and `cpu_rdata` equals `mem_rdata` in that cycle.
- R5: While a fill is still running, an access to a word that has already arrived completes without stalling. An access to a word that has not yet arrived stalls until the memory delivers that word.
- R6: A write hit replaces the addressed word and marks it modified. A later read of that word returns the written value.
- R7: Eviction writes to memory only the words marked modified, in ascending offset order, at the old tag's addresses, carrying the cached data.
- R8: All writebacks complete before the first fill read is issued. A line with no modified words is replaced without any memory write.
- R9: On a write miss the line is fetched. The addressed word takes the processor's data instead of the memory's and is marked modified.
- R10: Once `mem_req` is raised, `mem_addr`, `mem_we` and `mem_wdata` hold steady until the cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request, held until it completes |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address {tag, index, offset} |
| cpu_wdata | input | DW | Write data |
| cpu_rdata | output | DW | Read data, valid when the access completes |
| cpu_stall | output | 1 | High while the pending access cannot complete |
| mem_req | output | 1 | Memory transfer request, held until acknowledged |
| mem_we | output | 1 | 1 = writeback word, 0 = fill read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Writeback data |
| mem_ack | input | 1 | One-cycle acknowledge of the current transfer |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |

## Verification
The bench builds the block with its default sizes: 16 lines of 4 words of 32 bits and a 10-bit word address. That leaves four tag bits, so several tags can be aimed at one index to force dirty and clean evictions. The bench's memory model answers each transfer after two idle cycles. With four words per line, every wrap position of the fill order shows up, and there is time to reach both an arrived word and a pending word while a fill is still running.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVICT = 2'd1,
    ST_FILL  = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/cwf_meta_store.sv
module cwf_meta_store #(
  parameter int LINES = 16,
  parameter int WORDS = 4,
  parameter int TAGW  = 4,
  localparam int IDXW = $clog2(LINES),
  localparam int OFFW = $clog2(WORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IDXW-1:0] rd_idx,
  output logic [TAGW-1:0] rd_tag,
  output logic [WORDS-1:0] rd_valid,
  output logic [WORDS-1:0] rd_dirty,
  input  logic            clr_en,
  input  logic [IDXW-1:0] clr_idx,
  input  logic [TAGW-1:0] clr_tag,
  input  logic            fill_set,
  input  logic [IDXW-1:0] fill_idx,
  input  logic [OFFW-1:0] fill_off,
  input  logic            wr_set,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [OFFW-1:0] wr_off
);
  logic [TAGW-1:0]  tag_q   [LINES];
  logic [WORDS-1:0] valid_q [LINES];
  logic [WORDS-1:0] dirty_q [LINES];

  assign rd_tag   = tag_q[rd_idx];
  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) begin
        tag_q[i]   <= '0;
        valid_q[i] <= '0;
        dirty_q[i] <= '0;
      end
    end else begin
      if (clr_en) begin
        tag_q[clr_idx]   <= clr_tag;
        valid_q[clr_idx] <= '0;
        dirty_q[clr_idx] <= '0;
      end
      if (fill_set) valid_q[fill_idx][fill_off] <= 1'b1;
      if (wr_set) begin
        valid_q[wr_idx][wr_off] <= 1'b1;
        dirty_q[wr_idx][wr_off] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cwf_data_store.sv
module cwf_data_store #(
  parameter int LINES = 16,
  parameter int WORDS = 4,
  parameter int DW    = 32,
  localparam int IDXW = $clog2(LINES),
  localparam int OFFW = $clog2(WORDS),
  localparam int DEPTH = LINES * WORDS
) (
  input  logic            clk,
  input  logic            fill_we,
  input  logic [IDXW-1:0] fill_idx,
  input  logic [OFFW-1:0] fill_off,
  input  logic [DW-1:0]   fill_data,
  input  logic            cpu_we,
  input  logic [IDXW-1:0] cpu_idx,
  input  logic [OFFW-1:0] cpu_off,
  input  logic [DW-1:0]   cpu_data,
  input  logic [IDXW-1:0] rd_idx,
  input  logic [OFFW-1:0] rd_off,
  output logic [DW-1:0]   rd_data,
  input  logic [IDXW-1:0] wb_idx,
  input  logic [OFFW-1:0] wb_off,
  output logic [DW-1:0]   wb_data
);
  logic [DW-1:0] ram [DEPTH];

  assign rd_data = ram[{rd_idx, rd_off}];
  assign wb_data = ram[{wb_idx, wb_off}];

  // the processor write is issued last so it wins over fill data on the same word
  always_ff @(posedge clk) begin
    if (fill_we) ram[{fill_idx, fill_off}] <= fill_data;
    if (cpu_we)  ram[{cpu_idx, cpu_off}]   <= cpu_data;
  end
endmodule

// File: rtl/cwf_ctrl.sv
module cwf_ctrl
  import cwf_pkg::*;
#(
  parameter int DW   = 32,
  parameter int OFFW = 2,
  parameter int IDXW = 4,
  parameter int TAGW = 4,
  localparam int AW    = TAGW + IDXW + OFFW,
  localparam int WORDS = 1 << OFFW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             miss,
  input  logic [IDXW-1:0]  req_idx,
  input  logic [TAGW-1:0]  req_tag,
  input  logic [OFFW-1:0]  req_off,
  input  logic [TAGW-1:0]  line_tag,
  input  logic [WORDS-1:0] line_dirty,
  input  logic [DW-1:0]    wb_data,
  output ctl_state_e       state,
  output logic [IDXW-1:0]  line_idx,
  output logic [TAGW-1:0]  fill_tag,
  output logic [OFFW-1:0]  fill_off,
  output logic             fill_we,
  output logic             clr_en,
  output logic [OFFW-1:0]  wb_off,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_ack
);
  ctl_state_e       st_q;
  logic [OFFW-1:0]  start_q, cnt_q;
  logic [TAGW-1:0]  old_tag_q;
  logic [WORDS-1:0] wb_mask_q;

  assign state    = st_q;
  assign fill_off = start_q + cnt_q;
  assign fill_we  = (st_q == ST_FILL) && mem_req && mem_ack;
  assign clr_en   = (st_q == ST_EVICT) && !mem_req && (wb_mask_q == '0);

  // lowest modified word goes out first
  always_comb begin
    wb_off = '0;
    for (int i = WORDS - 1; i >= 0; i--)
      if (wb_mask_q[i]) wb_off = OFFW'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      line_idx  <= '0;
      fill_tag  <= '0;
      start_q   <= '0;
      cnt_q     <= '0;
      old_tag_q <= '0;
      wb_mask_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (miss) begin
          line_idx  <= req_idx;
          fill_tag  <= req_tag;
          start_q   <= req_off;
          old_tag_q <= line_tag;
          wb_mask_q <= line_dirty;
          st_q      <= ST_EVICT;
        end
        ST_EVICT: begin
          if (!mem_req) begin
            if (wb_mask_q == '0) begin
              st_q     <= ST_FILL;
              cnt_q    <= '0;
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= {fill_tag, line_idx, start_q};
            end else begin
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= {old_tag_q, line_idx, wb_off};
              mem_wdata <= wb_data;
            end
          end else if (mem_ack) begin
            mem_req           <= 1'b0;
            mem_we            <= 1'b0;
            wb_mask_q[wb_off] <= 1'b0;
          end
        end
        ST_FILL: if (mem_req && mem_ack) begin
          if (cnt_q == OFFW'(WORDS - 1)) begin
            mem_req <= 1'b0;
            st_q    <= ST_IDLE;
          end else begin
            cnt_q    <= cnt_q + 1'b1;
            mem_addr <= {fill_tag, line_idx, fill_off + 1'b1};
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cwf_cache.sv
module cwf_cache
  import cwf_pkg::*;
#(
  parameter int AW    = 10,
  parameter int DW    = 32,
  parameter int LINES = 16,
  parameter int WORDS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_stall,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  localparam int OFFW = $clog2(WORDS);
  localparam int IDXW = $clog2(LINES);
  localparam int TAGW = AW - IDXW - OFFW;

  logic [OFFW-1:0]  c_off, fill_off, wb_off;
  logic [IDXW-1:0]  c_idx, line_idx;
  logic [TAGW-1:0]  c_tag, rd_tag, fill_tag;
  logic [WORDS-1:0] rd_valid, rd_dirty;
  logic [DW-1:0]    rd_data, wb_data;
  logic             fill_we, clr_en, hit, bypass, done, miss, cpu_wr;
  ctl_state_e       state;

  assign c_off = cpu_addr[OFFW-1:0];
  assign c_idx = cpu_addr[OFFW +: IDXW];
  assign c_tag = cpu_addr[AW-1 -: TAGW];

  assign hit    = cpu_req && (rd_tag == c_tag) && rd_valid[c_off];
  assign bypass = cpu_req && fill_we && (c_idx == line_idx) &&
                  (c_tag == fill_tag) && (c_off == fill_off);
  assign done   = hit || bypass;
  assign miss   = cpu_req && !hit && (state == ST_IDLE);
  assign cpu_wr = done && cpu_we;

  assign cpu_stall = cpu_req && !done;
  assign cpu_rdata = bypass ? mem_rdata : rd_data;

  cwf_meta_store #(.LINES(LINES), .WORDS(WORDS), .TAGW(TAGW)) u_meta (
    .clk(clk), .rst(rst),
    .rd_idx(c_idx), .rd_tag(rd_tag), .rd_valid(rd_valid), .rd_dirty(rd_dirty),
    .clr_en(clr_en), .clr_idx(line_idx), .clr_tag(fill_tag),
    .fill_set(fill_we), .fill_idx(line_idx), .fill_off(fill_off),
    .wr_set(cpu_wr), .wr_idx(c_idx), .wr_off(c_off)
  );

  cwf_data_store #(.LINES(LINES), .WORDS(WORDS), .DW(DW)) u_data (
    .clk(clk),
    .fill_we(fill_we), .fill_idx(line_idx), .fill_off(fill_off), .fill_data(mem_rdata),
    .cpu_we(cpu_wr), .cpu_idx(c_idx), .cpu_off(c_off), .cpu_data(cpu_wdata),
    .rd_idx(c_idx), .rd_off(c_off), .rd_data(rd_data),
    .wb_idx(line_idx), .wb_off(wb_off), .wb_data(wb_data)
  );

  cwf_ctrl #(.DW(DW), .OFFW(OFFW), .IDXW(IDXW), .TAGW(TAGW)) u_ctrl (
    .clk(clk), .rst(rst),
    .miss(miss), .req_idx(c_idx), .req_tag(c_tag), .req_off(c_off),
    .line_tag(rd_tag), .line_dirty(rd_dirty), .wb_data(wb_data),
    .state(state), .line_idx(line_idx), .fill_tag(fill_tag), .fill_off(fill_off),
    .fill_we(fill_we), .clr_en(clr_en), .wb_off(wb_off),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack)
  );
endmodule

// File: rtl/cwf_checker.sv
module cwf_checker #(
  parameter int AW   = 10,
  parameter int DW   = 32,
  parameter int OFFW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          cpu_req,
  input logic          cpu_we,
  input logic [AW-1:0] cpu_addr,
  input logic [DW-1:0] cpu_rdata,
  input logic          cpu_stall,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ack,
  input logic [DW-1:0] mem_rdata
);
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) &&
                               $stable(mem_wdata)));

  assert_fill_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack && !mem_we) |=>
      (!mem_req || (!mem_we &&
        mem_addr[AW-1:OFFW] == $past(mem_addr[AW-1:OFFW]) &&
        mem_addr[OFFW-1:0] == OFFW'($past(mem_addr[OFFW-1:0]) + 1'b1))));

  assert_crit_data_R4: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_stall && !cpu_we && mem_req && mem_ack && !mem_we &&
     mem_addr == cpu_addr) |-> (cpu_rdata == mem_rdata));

  assert_wb_before_fill_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack && !mem_we) |=> !(mem_req && mem_we));
endmodule

bind cwf_cache cwf_checker #(.AW(AW), .DW(DW), .OFFW($clog2(WORDS))) u_chk (
  .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
);

// File: tb/tb_cwf_cache.sv
module tb_cwf_cache;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int LAT = 2;
  localparam int NV = 14;

  // {we, addr, wdata}
  localparam logic [42:0] VEC [NV] = '{
    {1'b0, 10'h000, 32'h0},
    {1'b1, 10'h001, 32'h1111_0001},
    {1'b0, 10'h001, 32'h0},
    {1'b0, 10'h045, 32'h0},
    {1'b1, 10'h046, 32'h2222_0002},
    {1'b0, 10'h041, 32'h0},
    {1'b0, 10'h001, 32'h0},
    {1'b1, 10'h10A, 32'h3333_0003},
    {1'b0, 10'h10A, 32'h0},
    {1'b0, 10'h20A, 32'h0},
    {1'b0, 10'h10A, 32'h0},
    {1'b0, 10'h046, 32'h0},
    {1'b1, 10'h3F4, 32'h4444_0004},
    {1'b0, 10'h3F7, 32'h0}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, cpu_rdata;
  logic cpu_stall, mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  cwf_cache #(.AW(AW), .DW(DW), .LINES(16), .WORDS(4)) dut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] initv(input int a);
    return 32'hC0DE_0000 + 32'(a) * 32'h0001_0003;
  endfunction

  logic [DW-1:0] mm [1024];
  logic [DW-1:0] shadow [1024];
  logic [AW-1:0] log_addr [256];
  logic          log_we   [256];
  logic [DW-1:0] log_data [256];
  int lognum = 0, wcnt = 0, hs_err = 0;
  logic prev_pend = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  int tests = 0, fails = 0;

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mm[i] = initv(i);
      shadow[i] = initv(i);
    end
  end

  // memory model: acknowledges each transfer after LAT waiting cycles
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      mem_rdata <= '0;
      wcnt <= 0;
      prev_pend <= 1'b0;
    end else begin
      if (mem_req && !mem_ack) begin
        if (wcnt == LAT) begin
          mem_ack <= 1'b1;
          mem_rdata <= mm[mem_addr];
          wcnt <= 0;
        end else wcnt <= wcnt + 1;
      end else mem_ack <= 1'b0;
      if (mem_req && mem_ack) begin
        if (mem_we) mm[mem_addr] <= mem_wdata;
        if (lognum < 256) begin
          log_addr[lognum] <= mem_addr;
          log_we[lognum] <= mem_we;
          log_data[lognum] <= mem_wdata;
        end
        lognum <= lognum + 1;
      end
      if (prev_pend && (!mem_req || mem_addr != prev_addr)) hs_err <= hs_err + 1;
      prev_pend <= mem_req && !mem_ack;
      prev_addr <= mem_addr;
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd, output int waits);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    waits = 0; rd = '0;
    forever begin
      #9;
      if (!cpu_stall) begin
        rd = cpu_rdata;
        @(posedge clk);
        break;
      end
      waits++;
      @(negedge clk);
      if (waits > 500) break;
    end
    @(negedge clk);
    cpu_req = 1'b0;
    if (we) shadow[a] = d;
  endtask

  task automatic settle();
    repeat (16) @(negedge clk);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd2000, 32'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    int w, base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #5;
    check(!cpu_stall && !mem_req, "R1 idle after reset", {30'd0, cpu_stall, mem_req}, 32'd0);

    // table walk against a shadow memory
    for (int i = 0; i < NV; i++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] expv;
      a = VEC[i][41:32];
      expv = shadow[a];
      access(VEC[i][42], a, VEC[i][31:0], rd, w);
      if (i == 0) check(w > 0, "R1 first access stalls", w, 32'd1);
      if (!VEC[i][42]) check(rd == expv, "R6/R7/R9 table read", rd, expv);
    end
    settle();

    // R3 R4 R5: critical word first on line tag1 idx3
    base = lognum;
    access(1'b0, 10'h04E, '0, rd, w);
    check(rd == initv('h04E), "R4 critical data", rd, initv('h04E));
    check(w > 0 && lognum == base + 1, "R4 release on critical word", lognum - base, 32'd1);
    access(1'b0, 10'h04E, '0, rd, w);
    check(w == 0 && lognum < base + 4, "R5 hit on arrived word mid-fill", w, 32'd0);
    access(1'b0, 10'h04F, '0, rd, w);
    check(rd == initv('h04F), "R5 pending word data", rd, initv('h04F));
    access(1'b0, 10'h04D, '0, rd, w);
    check(rd == initv('h04D) && lognum == base + 4, "R5 last word waits", lognum - base, 32'd4);
    check(log_addr[base] == 10'h04E && log_addr[base+1] == 10'h04F &&
          log_addr[base+2] == 10'h04C && log_addr[base+3] == 10'h04D,
          "R3 wrap order", {log_addr[base+2], log_addr[base+3]}, {10'h04C, 10'h04D});

    // R2: whole line hits with no traffic
    base = lognum;
    for (int k = 0; k < 4; k++) begin
      access(1'b0, 10'h04C + 10'(k), '0, rd, w);
      check(w == 0 && rd == initv('h04C + k), "R2 line hit", rd, initv('h04C + k));
    end
    check(lognum == base, "R2 no memory traffic", lognum - base, 32'd0);

    // R6: write hits
    access(1'b1, 10'h04C, 32'hDEAD_0000, rd, w);
    access(1'b1, 10'h04F, 32'hDEAD_0003, rd, w);
    access(1'b0, 10'h04C, '0, rd, w);
    check(rd == 32'hDEAD_0000 && w == 0, "R6 write hit readback", rd, 32'hDEAD_0000);

    // R7 R8: dirty eviction
    base = lognum;
    access(1'b0, 10'h08D, '0, rd, w);
    check(rd == initv('h08D), "R7 miss data after writeback", rd, initv('h08D));
    check(log_we[base] && log_addr[base] == 10'h04C && log_data[base] == 32'hDEAD_0000,
          "R7 first writeback", log_data[base], 32'hDEAD_0000);
    check(log_we[base+1] && log_addr[base+1] == 10'h04F && log_data[base+1] == 32'hDEAD_0003,
          "R7 second writeback", {22'd0, log_addr[base+1]}, 32'h04F);
    check(!log_we[base+2] && log_addr[base+2] == 10'h08D, "R8 fill after writeback",
          {22'd0, log_addr[base+2]}, 32'h08D);
    settle();
    check(mm[10'h04F] == 32'hDEAD_0003, "R7 memory updated", mm[10'h04F], 32'hDEAD_0003);

    // R8: clean eviction makes no write
    base = lognum;
    access(1'b0, 10'h14C, '0, rd, w);
    check(!log_we[base] && log_addr[base] == 10'h14C, "R8 clean eviction",
          {31'd0, log_we[base]}, 32'd0);
    settle();

    // R9: write miss
    access(1'b1, 10'h0DD, 32'hCAFE_F00D, rd, w);
    access(1'b0, 10'h0DD, '0, rd, w);
    check(rd == 32'hCAFE_F00D, "R9 write miss data", rd, 32'hCAFE_F00D);
    access(1'b0, 10'h0DC, '0, rd, w);
    check(rd == initv('h0DC), "R9 neighbour from memory", rd, initv('h0DC));
    settle();
    base = lognum;
    access(1'b0, 10'h11E, '0, rd, w);
    check(log_we[base] && log_addr[base] == 10'h0DD && log_data[base] == 32'hCAFE_F00D,
          "R9 written word dirty", log_data[base], 32'hCAFE_F00D);
    check(!log_we[base+1] && log_addr[base+1] == 10'h11E, "R7 only dirty word written",
          {22'd0, log_addr[base+1]}, 32'h11E);
    settle();

    check(hs_err == 0, "R10 request held until ack", hs_err, 32'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule